// File: doc/BRIEF.md
# Periodic Wake-up and Reset Timer

This block turns a slow, already prescaled timing tick into two periodic events. A wake-up counter counts ticks and, each time it has seen the programmed number of them, wraps to zero and raises a wake-up flag. A second counter, cascaded behind the first, counts those wake-up events and, after its own programmed number, wraps and raises a periodic reset request. The periodic reset interval is therefore the wake-up interval multiplied by the reset count, anywhere from 1 to 255 wake-up events.

Software configures both counts through a small register port with four addresses. Any accepted write that changes a count restarts the matching counter from zero, and a write of the value already held does nothing. A zero count switches the matching function off. An interlock refuses any write that would switch off both the wake-up and the periodic reset at the same time. Both flags hold until software clears them with write-one-to-clear bits. A select bit chooses which counter appears in a read-only status register.

Top module: `pwr_wake_timer`

## Requirements
- R1: After reset the interval register (address 0) and the reset-count register (address 1) read 0xFF, the control register (address 2) reads 0, both counters are 0 and both flags are low.
- R2: With an interval value N of 1 or more, the wake-up counter advances by one per tick. On the N-th tick it wraps to 0 and sets the wake-up flag, so a status read right after the event returns 0.
- R3: With a reset-count value M of 1 or more, the reset counter advances once per wake-up event. On the M-th event it wraps to 0 and sets the reset request, so the reset request follows every N*M ticks.
- R4: An accepted write to address 0 or address 1 with a value different from the one held clears the matching counter to 0 on that cycle. The clear takes priority over a tick or wake-up event arriving on the same cycle.
- R5: A write of the value already held in address 0 or address 1 changes nothing and does not restart the counter.
- R6: A reset-count value of 0, accepted while the interval is nonzero, disables the periodic reset: the reset counter stays at 0 and the reset request is never set.
- R7: A write of 0 to address 1 is ignored while the interval is 0, and a write of 0 to address 0 is ignored while the reset count is 0, so the two values are never both 0.
- R8: An interval value of 0 disables the wake-up function: the wake-up counter stays at 0, no wake-up flag is set and the reset counter does not advance.
- R9: Both flags are sticky. Writing address 2 with bit 1 set clears the wake-up flag, and with bit 2 set clears the reset request. A flag set on the same cycle as its clear stays set.
- R10: Address 2 stores the select in bit 0 and reads back {0..0, reset request, wake-up flag, select} in bits [2:0]. Address 3 is read-only and shows the wake-up counter when select is 0 and the reset counter when select is 1. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Prescaled wake-up tick, one cycle per tick |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address for both read and write |
| reg_wdata_i | input | CNT_W | Register write data |
| reg_rdata_o | output | CNT_W | Register read data for reg_addr_i |
| wake_flag_o | output | 1 | Sticky wake-up flag |
| rst_req_o | output | 1 | Sticky periodic reset request |

## Verification
The assertions assume that tick_i and the register strobe are sampled cleanly once per clock and that a write strobe is a single-cycle event with stable address and data, so every write is judged against the values held before that edge. The bench drives all inputs half a cycle away from the sampling edge and drops the strobe and tick after each step. Random stimulus is limited to small count values (0 to 4) and sparse writes. This lets wraps, restarts, refused zero writes and flag set/clear collisions all occur often within a short run.

// File: rtl/pwt_pkg.sv
// Package: shared register map and control-bit positions for the
// periodic wake-up and reset timer. Assumes a 2-bit register address.
package pwt_pkg;

    typedef enum logic [1:0] {
        ADDR_INTERVAL = 2'd0,
        ADDR_RSTCNT   = 2'd1,
        ADDR_CTRL     = 2'd2,
        ADDR_STATUS   = 2'd3
    } pwt_addr_e;

    localparam int CTRL_SEL_BIT      = 0;
    localparam int CTRL_CLR_WAKE_BIT = 1;
    localparam int CTRL_CLR_RST_BIT  = 2;

endpackage

// File: rtl/pwt_modcnt.sv
// Module: modulo event counter. Counts step pulses from 0 up to limit-1,
// then wraps to 0 and emits a one-cycle wrap pulse. A limit of 0 disables
// counting. A clear request wins over a step on the same cycle.
// Assumes: limit_i only changes together with a clear_i pulse.
module pwt_modcnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         step_i,
    input  logic [W-1:0] limit_i,
    output logic [W-1:0] count_o,
    output logic         wrap_o
);

    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] ZERO = '0;

    logic [W-1:0] count_q;
    logic         enabled;
    logic         at_end;

    // Decode whether counting is on and whether the next step wraps.
    always_comb begin
        enabled = (limit_i != ZERO);
        at_end  = (count_q == (limit_i - ONE));
        wrap_o  = step_i && enabled && !clear_i && at_end;
    end

    // Count register: reset, restart, wrap or advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= ZERO;
        end else if (clear_i) begin
            count_q <= ZERO;
        end else if (step_i && enabled) begin
            count_q <= at_end ? ZERO : (count_q + ONE);
        end
    end

    assign count_o = count_q;

    // R2: the count always stays inside the programmed range.
    a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (limit_i != ZERO) ? (count_q < limit_i) : (count_q == ZERO));

    // R2: a wrap leaves the counter at zero.
    a_r2_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |=> (count_q == ZERO));

    // R4: a restart leaves the counter at zero.
    a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (count_q == ZERO));

    // R8: without a usable step the count holds.
    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear_i && !(step_i && enabled)) |=> $stable(count_q));

endmodule

// File: rtl/pwt_regs.sv
// Module: configuration registers for the timer. Holds the wake-up
// interval, the reset count and the status select. Applies the interlock
// that refuses to zero one count while the other is zero, and reports
// which counter must restart because its count really changed.
// Assumes: W >= 3 so the control bits fit in the data word.
module pwt_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [1:0]   addr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] interval_o,
    output logic [W-1:0] rstcnt_o,
    output logic         sel_o,
    output logic         wake_restart_o,
    output logic         rst_restart_o,
    output logic         clr_wake_o,
    output logic         clr_rst_o
);

    import pwt_pkg::*;

    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ZERO     = '0;

    logic [W-1:0] interval_q;
    logic [W-1:0] rstcnt_q;
    logic         sel_q;
    logic         hit_int;
    logic         hit_rc;
    logic         hit_ctrl;
    logic         unused_ctrl_bits;

    // Address decode and write acceptance with the interlock.
    always_comb begin
        hit_int        = we_i && (addr_i == ADDR_INTERVAL);
        hit_rc         = we_i && (addr_i == ADDR_RSTCNT);
        hit_ctrl       = we_i && (addr_i == ADDR_CTRL);
        wake_restart_o = hit_int && (wdata_i != interval_q)
                         && !((wdata_i == ZERO) && (rstcnt_q == ZERO));
        rst_restart_o  = hit_rc && (wdata_i != rstcnt_q)
                         && !((wdata_i == ZERO) && (interval_q == ZERO));
        clr_wake_o     = hit_ctrl && wdata_i[CTRL_CLR_WAKE_BIT];
        clr_rst_o      = hit_ctrl && wdata_i[CTRL_CLR_RST_BIT];
    end

    assign unused_ctrl_bits = ^wdata_i[W-1:3];

    // Register storage updated only by accepted writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= ALL_ONES;
            rstcnt_q   <= ALL_ONES;
            sel_q      <= 1'b0;
        end else begin
            if (wake_restart_o) interval_q <= wdata_i;
            if (rst_restart_o)  rstcnt_q   <= wdata_i;
            if (hit_ctrl)       sel_q      <= wdata_i[CTRL_SEL_BIT];
        end
    end

    assign interval_o = interval_q;
    assign rstcnt_o   = rstcnt_q;
    assign sel_o      = sel_q;

    // R7: the two counts are never zero together.
    a_r7_never_both_off: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_q != ZERO) || (rstcnt_q != ZERO));

    // R7: a refused zero write leaves the reset count nonzero.
    a_r7_zero_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rc && (wdata_i == ZERO) && (interval_q == ZERO)) |=> (rstcnt_q != ZERO));

    // R5: a same-value write leaves the reset count untouched.
    a_r5_same_value_rc: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_rc && (wdata_i == rstcnt_q)) |=> $stable(rstcnt_q));

    // R5: a same-value write leaves the interval untouched.
    a_r5_same_value_int: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_int && (wdata_i == interval_q)) |=> $stable(interval_q));

endmodule

// File: rtl/pwr_wake_timer.sv
// Module: periodic wake-up and reset timer top. A wake-up counter divides
// the incoming tick by the interval value; its wraps feed a reset counter
// that divides them by the reset count. Both wraps set sticky flags that
// software clears with write-one-to-clear bits. The read port is
// combinational. Assumes: tick_i is a one-cycle pulse per prescaled tick.
module pwr_wake_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             reg_we_i,
    input  logic [1:0]       reg_addr_i,
    input  logic [CNT_W-1:0] reg_wdata_i,
    output logic [CNT_W-1:0] reg_rdata_o,
    output logic             wake_flag_o,
    output logic             rst_req_o
);

    import pwt_pkg::*;

    localparam int PAD_W = CNT_W - 3;

    logic [CNT_W-1:0] interval;
    logic [CNT_W-1:0] rstcnt;
    logic [CNT_W-1:0] wake_count;
    logic [CNT_W-1:0] rst_count;
    logic             sel;
    logic             wake_restart;
    logic             rst_restart;
    logic             clr_wake;
    logic             clr_rst;
    logic             wake_wrap;
    logic             rst_wrap;
    logic             wake_flag_q;
    logic             rst_flag_q;

    pwt_regs #(.W(CNT_W)) regs_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .we_i           (reg_we_i),
        .addr_i         (reg_addr_i),
        .wdata_i        (reg_wdata_i),
        .interval_o     (interval),
        .rstcnt_o       (rstcnt),
        .sel_o          (sel),
        .wake_restart_o (wake_restart),
        .rst_restart_o  (rst_restart),
        .clr_wake_o     (clr_wake),
        .clr_rst_o      (clr_rst)
    );

    pwt_modcnt #(.W(CNT_W)) wake_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (wake_restart),
        .step_i  (tick_i),
        .limit_i (interval),
        .count_o (wake_count),
        .wrap_o  (wake_wrap)
    );

    pwt_modcnt #(.W(CNT_W)) rst_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (rst_restart),
        .step_i  (wake_wrap),
        .limit_i (rstcnt),
        .count_o (rst_count),
        .wrap_o  (rst_wrap)
    );

    // Sticky flags: a new event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_flag_q <= 1'b0;
            rst_flag_q  <= 1'b0;
        end else begin
            wake_flag_q <= wake_wrap | (wake_flag_q & ~clr_wake);
            rst_flag_q  <= rst_wrap  | (rst_flag_q  & ~clr_rst);
        end
    end

    // Combinational read mux over the four addresses.
    always_comb begin
        case (reg_addr_i)
            ADDR_INTERVAL: reg_rdata_o = interval;
            ADDR_RSTCNT:   reg_rdata_o = rstcnt;
            ADDR_CTRL:     reg_rdata_o = {{PAD_W{1'b0}}, rst_flag_q, wake_flag_q, sel};
            default:       reg_rdata_o = sel ? rst_count : wake_count;
        endcase
    end

    assign wake_flag_o = wake_flag_q;
    assign rst_req_o   = rst_flag_q;

    // R9: the wake-up flag stays set until cleared.
    a_r9_wake_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag_q && !clr_wake) |=> wake_flag_q);

    // R9: the reset request stays set until cleared.
    a_r9_rst_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_flag_q && !clr_rst) |=> rst_flag_q);

    // R3: a reset request only appears after a wake-up event.
    a_r3_rst_after_wake: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_flag_q) |-> $past(wake_wrap));

    // R8: no wake-up event while the interval is zero.
    a_r8_no_wake_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (interval == '0) |-> !wake_wrap);

    // R6: no reset event while the reset count is zero.
    a_r6_no_rst_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (rstcnt == '0) |-> !rst_wrap);

endmodule

// File: tb/pwr_wake_timer_tb_top.sv
`timescale 1ns/1ps
module pwr_wake_timer_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_i = 1'b0;
    logic       reg_we_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'd0;
    logic [7:0] reg_rdata_o;
    logic       wake_flag_o;
    logic       rst_req_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // Bench-side expectation state.
    logic [7:0] m_int, m_rc, m_wc, m_rcnt;
    bit m_sel, m_wf, m_rf;

    always #4 clk = ~clk;

    pwr_wake_timer #(.CNT_W(8)) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick_i),
        .reg_we_i    (reg_we_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .wake_flag_o (wake_flag_o),
        .rst_req_o   (rst_req_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_int = 8'hFF; m_rc = 8'hFF; m_wc = 8'h00; m_rcnt = 8'h00;
        m_sel = 1'b0; m_wf = 1'b0; m_rf = 1'b0;
    endtask

    // Expected effect of one clock edge, from the requirements.
    task automatic model_edge(input bit tk, input bit we, input logic [1:0] a, input logic [7:0] d);
        bit wrs, rrs, wwrap, rwrap, clw, clr;
        wrs   = we && a == 2'd0 && d != m_int && !(d == 8'd0 && m_rc == 8'd0);
        rrs   = we && a == 2'd1 && d != m_rc  && !(d == 8'd0 && m_int == 8'd0);
        wwrap = !wrs && tk && m_int != 0 && m_wc == m_int - 8'd1;
        rwrap = !rrs && wwrap && m_rc != 0 && m_rcnt == m_rc - 8'd1;
        clw   = we && a == 2'd2 && d[1];
        clr   = we && a == 2'd2 && d[2];
        if (wrs) m_wc = 8'd0;
        else if (tk && m_int != 0) m_wc = wwrap ? 8'd0 : m_wc + 8'd1;
        if (rrs) m_rcnt = 8'd0;
        else if (wwrap && m_rc != 0) m_rcnt = rwrap ? 8'd0 : m_rcnt + 8'd1;
        if (wrs) m_int = d;
        if (rrs) m_rc = d;
        if (we && a == 2'd2) m_sel = d[0];
        m_wf = wwrap | (m_wf & !clw);
        m_rf = rwrap | (m_rf & !clr);
    endtask

    task automatic step(input bit tk, input bit we, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        tick_i = tk; reg_we_i = we; reg_addr_i = a; reg_wdata_i = d;
        @(posedge clk);
        model_edge(tk, we, a, d);
        #1;
        tick_i = 1'b0; reg_we_i = 1'b0;
        chk("R9 wake flag", int'(wake_flag_o), int'(m_wf));
        chk("R3 reset request", int'(rst_req_o), int'(m_rf));
    endtask

    task automatic rd(input logic [1:0] a, input int exp, input string tag);
        reg_addr_i = a;
        #1;
        chk(tag, int'(reg_rdata_o), exp);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 1'b0, 2'd0, 8'd0);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(1'b0, 1'b1, a, d);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'h5EED_0042);
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state.
        rd(2'd0, 8'hFF, "R1 interval reset");
        rd(2'd1, 8'hFF, "R1 reset count reset");
        rd(2'd2, 0, "R1 control reset");
        rd(2'd3, 0, "R1 wake counter reset");
        chk("R1 wake flag reset", int'(wake_flag_o), 0);
        chk("R1 reset request reset", int'(rst_req_o), 0);

        // R2/R3/R10: interval 3, reset count 2.
        wr(2'd0, 8'd3);
        wr(2'd1, 8'd2);
        ticks(2);
        rd(2'd3, 2, "R2 wake counter advances");
        ticks(1);
        chk("R2 wake flag after third tick", int'(wake_flag_o), 1);
        rd(2'd3, 0, "R2 status zero after wrap");
        wr(2'd2, 8'b001);
        rd(2'd3, 1, "R10 select shows reset counter");
        rd(2'd2, 3, "R10 control readback");
        wr(2'd2, 8'b011);
        chk("R9 wake flag cleared", int'(wake_flag_o), 0);
        ticks(3);
        chk("R3 reset request after 6 ticks", int'(rst_req_o), 1);
        rd(2'd3, 0, "R3 reset counter wrapped");
        wr(2'd2, 8'b101);
        chk("R9 reset request cleared", int'(rst_req_o), 0);

        // R5/R4: same-value write vs changing write.
        ticks(3);
        rd(2'd3, 1, "R3 reset counter at one");
        wr(2'd1, 8'd2);
        rd(2'd3, 1, "R5 same value keeps count");
        wr(2'd1, 8'd3);
        rd(2'd3, 0, "R4 changed value restarts");

        // R6: reset count zero with interval nonzero.
        wr(2'd1, 8'd0);
        rd(2'd1, 0, "R6 zero reset count accepted");
        wr(2'd2, 8'b111);
        ticks(12);
        chk("R6 no reset request", int'(rst_req_o), 0);
        rd(2'd3, 0, "R6 reset counter held");

        // R7: interlock in both directions.
        wr(2'd0, 8'd0);
        rd(2'd0, 3, "R7 zero interval refused");
        wr(2'd1, 8'd4);
        wr(2'd0, 8'd0);
        rd(2'd0, 0, "R7 zero interval accepted");
        wr(2'd1, 8'd0);
        rd(2'd1, 4, "R7 zero reset count refused");

        // R8: interval zero stops everything.
        wr(2'd2, 8'b110);
        ticks(5);
        chk("R8 no wake flag", int'(wake_flag_o), 0);
        rd(2'd3, 0, "R8 wake counter held");
        wr(2'd2, 8'b001);
        rd(2'd3, 0, "R8 reset counter held");

        // Random phase against the expectation model.
        wr(2'd0, 8'd2);
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit tk;
            r  = int'($urandom % 100);
            tk = bit'($urandom % 2);
            if (r < 4)       step(tk, 1'b1, 2'd0, 8'($urandom % 5));
            else if (r < 8)  step(tk, 1'b1, 2'd1, 8'($urandom % 5));
            else if (r < 12) step(tk, 1'b1, 2'd2, 8'($urandom % 8));
            else             step(tk, 1'b0, 2'd0, 8'd0);
            rd(2'd3, int'(m_sel ? m_rcnt : m_wc), "R10 status random");
            rd(2'd2, int'({m_rf, m_wf, m_sel}), "R10 control random");
            if (r % 10 == 0) begin
                rd(2'd0, int'(m_int), "R7 interval random");
                rd(2'd1, int'(m_rc), "R7 reset count random");
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule